// File: doc/BRIEF.md
# Byte-Lane Write and Output Control

This block handles the data side of a small synchronous memory with two 8-bit lanes, each with its own parity bit. The address path sits outside the block. It delivers a word address and a "device selected" flag for every clock. The block turns three active-low write strobes into per-lane write enables: a global write, a byte-write enable and one byte select per lane. On the rising clock edge it stores the lane data from the bus into an internal array.

On a selected read cycle, the block registers the address at the rising edge. After that edge it presents the stored word on its output lines. It also raises a pad drive enable for the shared bus. The pad drive is gated by an active-low output enable, which acts without waiting for the clock. Any write cycle forces the drivers off for the cycle that follows it, whatever the output enable says.

The shared bus appears as separate input lines, output lines and one drive-enable signal. The pad ring that uses these signals is outside the block.

Top module: `bl_wr_ctl`

## Requirements
- R1: During reset and after reset is released, `drv_en_o` is low until a selected read cycle has been sampled.
- R2: When the device is selected and `gw_n_i` is low at a rising edge, both lanes are written at `addr_i`, whatever `bwe_n_i` and `bsel_n_i` are.
- R3: When the device is selected, `gw_n_i` is high and `bwe_n_i` is low, lane i is written only when `bsel_n_i[i]` is low.
- R4: Lane 0 holds `dq_i[7:0]` and parity `dp_i[0]`. Lane 1 holds `dq_i[15:8]` and parity `dp_i[1]`. Parity bits are stored and returned unchanged, with no generation or checking.
- R5: A selected cycle with `gw_n_i` high, `bwe_n_i` low and both byte selects high leaves every stored word unchanged.
- R6: A selected cycle with `gw_n_i` and `bwe_n_i` both high is a read. After that rising edge, `dq_o` and `dp_o` carry the word at the address sampled at that edge. `drv_en_o` is high if `oe_n_i` is low.
- R7: `oe_n_i` high forces `drv_en_o` low at once, with no clock edge needed. Bringing `oe_n_i` low again restores the drive after a read.
- R8: After a selected write cycle (`gw_n_i` low or `bwe_n_i` low), `drv_en_o` is low for the following clock period, even with `oe_n_i` low.
- R9: A cycle with `sel_i` low writes nothing and turns `drv_en_o` off for the following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Device selected this cycle (from address front end) |
| addr_i | input | ADDR_W | Word address from the address front end |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| bsel_n_i | input | LANES | Per-lane byte selects, active low |
| oe_n_i | input | 1 | Output enable, active low, not clocked |
| dq_i | input | LANES*8 | Data lines as seen from the pads |
| dp_i | input | LANES | Parity lines as seen from the pads |
| dq_o | output | LANES*8 | Read data toward the pads |
| dp_o | output | LANES | Read parity toward the pads |
| drv_en_o | output | 1 | Pad drive enable for data and parity lines |

## Verification
The bench builds the block with `ADDR_W` = 4. That gives a 16-word array, so every location can be written with a known pattern and read back. Each byte-lane combination, the write of nothing, and the deselected write can then be checked against a full reference copy. `LANES` stays at 2, which puts both parity bits and the per-lane masking within reach. Back-to-back reads at different addresses and toggling the output enable in the middle of a cycle exercise the registered read address and the drive gate that needs no clock.

// File: rtl/bl_pkg.sv
package bl_pkg;

  // Kind of bus cycle decoded from the write strobes.
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;

endpackage

// File: rtl/bl_lane_dec.sv
module bl_lane_dec
  import bl_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             sel_i,
  input  logic             gw_n_i,
  input  logic             bwe_n_i,
  input  logic [LANES-1:0] bsel_n_i,
  output logic [LANES-1:0] lane_we_o,
  output cyc_kind_e        kind_o
);

  // The global strobe wins over the byte-write scheme.
  // Without a selection nothing is decoded.
  always_comb begin
    kind_o    = CYC_IDLE;
    lane_we_o = '0;
    if (sel_i) begin
      if (!gw_n_i) begin
        kind_o    = CYC_WRITE;
        lane_we_o = '1;
      end else if (!bwe_n_i) begin
        kind_o    = CYC_WRITE;
        lane_we_o = ~bsel_n_i;
      end else begin
        kind_o    = CYC_READ;
      end
    end
  end

endmodule

// File: rtl/bl_lane_store.sv
module bl_lane_store #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  // Bus data is captured straight into the addressed word on the edge.
  always_ff @(posedge clk) begin
    if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/bl_out_gate.sv
module bl_out_gate
  import bl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cyc_kind_e kind_i,
  input  logic      oe_n_i,
  output logic      drv_en_o
);

  logic rd_d, rd_q;

  // Only a read arms the drivers; a write or an idle cycle disarms them.
  always_comb begin
    rd_d = (kind_i == CYC_READ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
    end else begin
      rd_q <= rd_d;
    end
  end

  // The output enable bypasses the clock.
  assign drv_en_o = rd_q & ~oe_n_i;

  AST_WRITE_KILLS_DRV: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == CYC_WRITE) |=> !drv_en_o); // R8
  AST_IDLE_DROPS_DRV: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == CYC_IDLE) |=> !drv_en_o); // R9
  AST_READ_FOLLOWS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == CYC_READ) |=> (drv_en_o == !oe_n_i)); // R6
  AST_OE_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !drv_en_o); // R7

endmodule

// File: rtl/bl_wr_ctl.sv
module bl_wr_ctl
  import bl_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LANES   = 2,
  parameter int LANE_DW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     gw_n_i,
  input  logic                     bwe_n_i,
  input  logic [LANES-1:0]         bsel_n_i,
  input  logic                     oe_n_i,
  input  logic [LANES*LANE_DW-1:0] dq_i,
  input  logic [LANES-1:0]         dp_i,
  output logic [LANES*LANE_DW-1:0] dq_o,
  output logic [LANES-1:0]         dp_o,
  output logic                     drv_en_o
);

  localparam int WORD_W = LANE_DW + 1;

  // Reset: asserted at once, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // Strobe decode.
  logic [LANES-1:0] lane_we;
  cyc_kind_e        kind;

  bl_lane_dec #(.LANES(LANES)) u_dec (
    .sel_i    (sel_i),
    .gw_n_i   (gw_n_i),
    .bwe_n_i  (bwe_n_i),
    .bsel_n_i (bsel_n_i),
    .lane_we_o(lane_we),
    .kind_o   (kind)
  );

  AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_i && !gw_n_i) |-> (&lane_we)); // R2
  AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !sel_i |-> (lane_we == '0)); // R9
  AST_NULL_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_i && gw_n_i && !bwe_n_i && (&bsel_n_i)) |-> (lane_we == '0)); // R5

  // Read address register, loaded only on selected cycles.
  logic [ADDR_W-1:0] raddr_d, raddr_q;

  always_comb begin
    raddr_d = raddr_q;
    if (sel_i) begin
      raddr_d = addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      raddr_q <= '0;
    end else begin
      raddr_q <= raddr_d;
    end
  end

  // One storage slice per lane: data byte plus its parity bit.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [WORD_W-1:0] wword, rword;

    assign wword = {dp_i[l], dq_i[l*LANE_DW +: LANE_DW]};

    bl_lane_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
      .clk    (clk),
      .we_i   (lane_we[l]),
      .waddr_i(addr_i),
      .wdata_i(wword),
      .raddr_i(raddr_q),
      .rdata_o(rword)
    );

    assign dq_o[l*LANE_DW +: LANE_DW] = rword[LANE_DW-1:0];
    assign dp_o[l]                    = rword[LANE_DW];

    AST_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_int_n)
      (sel_i && gw_n_i && !bwe_n_i) |-> (lane_we[l] == !bsel_n_i[l])); // R3
  end

  bl_out_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .kind_i  (kind),
    .oe_n_i  (oe_n_i),
    .drv_en_o(drv_en_o)
  );

endmodule

// File: tb/bl_wr_ctl_bench.sv
`timescale 1ns/1ps
module bl_wr_ctl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel;
  logic [3:0]  addr;
  logic        gw_n, bwe_n, oe_n;
  logic [1:0]  bsel_n;
  logic [15:0] dq_in;
  logic [1:0]  dp_in;
  logic [15:0] dq_out;
  logic [1:0]  dp_out;
  logic        drv_en;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  bl_wr_ctl #(.ADDR_W(4), .LANES(2), .LANE_DW(8)) u_bl_wr_ctl (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .addr_i(addr),
    .gw_n_i(gw_n), .bwe_n_i(bwe_n), .bsel_n_i(bsel_n), .oe_n_i(oe_n),
    .dq_i(dq_in), .dp_i(dp_in), .dq_o(dq_out), .dp_o(dp_out),
    .drv_en_o(drv_en)
  );

  // Reference copy of the array, built from the requirements.
  logic [15:0] m_dq [16];
  logic [1:0]  m_dp [16];

  // Item: [19] drive expected, [18] data checked, [17:16] parity, [15:0] data.
  logic [19:0] q_item [$];
  string       q_tag  [$];

  task automatic check1(input logic ok, input string tag, input string what,
                        input logic [19:0] act, input logic [19:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic [3:0] a, input logic gw,
                     input logic bw, input logic [1:0] bs, input logic oe,
                     input logic [15:0] d, input logic [1:0] p, input string tag);
    logic rd;
    logic [19:0] it;
    @(negedge clk);
    sel = s; addr = a; gw_n = gw; bwe_n = bw; bsel_n = bs; oe_n = oe;
    dq_in = d; dp_in = p;
    rd = s && gw && bw;
    it = {rd && !oe, rd, m_dp[a], m_dq[a]};
    if (s && (!gw || (!bw && !bs[0]))) begin
      m_dq[a][7:0] = d[7:0];  m_dp[a][0] = p[0];
    end
    if (s && (!gw || (!bw && !bs[1]))) begin
      m_dq[a][15:8] = d[15:8]; m_dp[a][1] = p[1];
    end
    q_item.push_back(it);
    q_tag.push_back(tag);
  endtask

  // Monitor: compares one item per rising edge, shortly after it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_item.size() > 0) begin
        logic [19:0] it;
        string tg;
        it = q_item.pop_front();
        tg = q_tag.pop_front();
        check1(drv_en === it[19], tg, "drive", {19'd0, drv_en}, {19'd0, it[19]});
        if (it[18] && it[19]) begin
          check1({dp_out, dq_out} === it[17:0], tg, "data",
                 {2'b0, dp_out, dq_out}, {2'b0, it[17:0]});
        end
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #50000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sel = 1'b0; addr = '0; gw_n = 1'b1; bwe_n = 1'b1;
    bsel_n = 2'b11; oe_n = 1'b0; dq_in = '0; dp_in = '0;
    repeat (3) @(negedge clk);
    check1(drv_en === 1'b0, "R1", "drive in reset", {19'd0, drv_en}, 20'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check1(drv_en === 1'b0, "R1", "drive after reset", {19'd0, drv_en}, 20'd0);

    // R2: global write fills every word; byte strobes set to misleading values.
    for (int i = 0; i < 16; i++) begin
      cyc(1'b1, 4'(i), 1'b0, i[0], 2'(i), 1'b0, 16'hA500 + 16'(i * 17),
          2'(i + 1), "R2_fill");
    end
    // R4: read back every word with both parity bits.
    for (int i = 0; i < 16; i++) begin
      cyc(1'b1, 4'(i), 1'b1, 1'b1, 2'b11, 1'b0, 16'h0, 2'b00, "R4_readback");
    end

    // R3: lane 0 only, lane 1 only, both lanes.
    cyc(1'b1, 4'd3, 1'b1, 1'b0, 2'b10, 1'b0, 16'h1234, 2'b11, "R3_lane0");
    cyc(1'b1, 4'd3, 1'b1, 1'b1, 2'b11, 1'b0, 16'h0, 2'b00, "R3_read3");
    cyc(1'b1, 4'd5, 1'b1, 1'b0, 2'b01, 1'b0, 16'h5678, 2'b10, "R3_lane1");
    cyc(1'b1, 4'd5, 1'b1, 1'b1, 2'b11, 1'b0, 16'h0, 2'b00, "R3_read5");
    cyc(1'b1, 4'd6, 1'b1, 1'b0, 2'b00, 1'b0, 16'h9ABC, 2'b01, "R3_both");
    cyc(1'b1, 4'd6, 1'b1, 1'b1, 2'b11, 1'b0, 16'h0, 2'b00, "R3_read6");

    // R5: byte write with no lane selected; R8 drive off after it.
    cyc(1'b1, 4'd7, 1'b1, 1'b0, 2'b11, 1'b0, 16'hFFFF, 2'b11, "R5_null");
    cyc(1'b1, 4'd7, 1'b1, 1'b1, 2'b11, 1'b0, 16'h0, 2'b00, "R5_read7");

    // R8: write right after a read, output enable held low.
    cyc(1'b1, 4'd9, 1'b0, 1'b1, 2'b11, 1'b0, 16'h0F0F, 2'b10, "R8_gw_after_read");
    cyc(1'b1, 4'd9, 1'b1, 1'b1, 2'b11, 1'b0, 16'h0, 2'b00, "R8_read9");

    // R9: deselected write leaves the word, drive drops.
    cyc(1'b0, 4'd10, 1'b0, 1'b0, 2'b00, 1'b0, 16'hDEAD, 2'b11, "R9_desel");
    cyc(1'b1, 4'd10, 1'b1, 1'b1, 2'b11, 1'b0, 16'h0, 2'b00, "R9_read10");

    // R6: back-to-back reads at different addresses.
    cyc(1'b1, 4'd0, 1'b1, 1'b1, 2'b11, 1'b0, 16'h0, 2'b00, "R6_read0");
    cyc(1'b1, 4'd15, 1'b1, 1'b1, 2'b11, 1'b0, 16'h0, 2'b00, "R6_read15");
    cyc(1'b1, 4'd6, 1'b1, 1'b1, 2'b11, 1'b1, 16'h0, 2'b00, "R7_read_oe_high");

    // R7: output enable toggled between edges after a read.
    cyc(1'b1, 4'd12, 1'b1, 1'b1, 2'b11, 1'b0, 16'h0, 2'b00, "R7_read12");
    @(negedge clk);
    #0.5 oe_n = 1'b1;
    #0.5 check1(drv_en === 1'b0, "R7", "oe high mid-cycle", {19'd0, drv_en}, 20'd0);
    oe_n = 1'b0;
    #0.5 check1(drv_en === 1'b1, "R7", "oe low again", {19'd0, drv_en}, 20'd1);

    cyc(1'b0, 4'd0, 1'b1, 1'b1, 2'b11, 1'b0, 16'h0, 2'b00, "R9_idle");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule